// File: doc/BRIEF.md
# CAN Fault Confinement Counters with Bus-Off Recovery

This block keeps the receive and transmit error counts of a CAN node, compares them with a programmable warning limit, and runs the bus-off state machine. Protocol logic sends it increment and decrement events and a pulse each time eleven recessive bits in a row are seen (bus-free). A CPU write port can change the counts and the limit, but only while the node is in reset mode. A CPU-driven change of status is only evaluated once reset mode is left.

When the transmit count would pass 255, the node goes bus-off. The receive count is cleared, the transmit count is loaded with 127 and a reset-mode request is raised. Once software leaves reset mode, recovery counts the transmit counter down by one per bus-free pulse. A pulse that arrives with the counter at 0 (the 128th) returns the node to normal operation. Software can cut recovery short by writing a value below 255 to the transmit counter. Writing 255 in reset mode forces a bus-off once reset mode is left.

The states are ACTIVE (counting), HOLD (reset mode, not bus-off), BOFF_HOLD (bus-off, reset mode), RECOVER (bus-off, counting bus-free pulses), PEND1 (reset mode after a recovery-cutting write) and WAIT1 (waiting for one bus-free pulse). The transitions are as follows:
- ACTIVE goes to BOFF_HOLD on transmit overflow, and to HOLD when reset mode is active.
- HOLD goes to BOFF_HOLD on exit with a count of 255, and to ACTIVE on any other exit.
- BOFF_HOLD goes to PEND1 when the transmit counter is written with 0 to 254, and to RECOVER on exit.
- RECOVER goes to BOFF_HOLD when reset mode is active, and to ACTIVE on a bus-free pulse with the count at 0.
- PEND1 goes to BOFF_HOLD on exit with a count of 255, and to WAIT1 on any other exit.
- WAIT1 goes to PEND1 when reset mode is active, and to ACTIVE on a bus-free pulse.

Reset mode is active when `rst_mode_i` is high or when the block's own `force_reset_o` request is pending.

Top module: `can_fault_confine`

## Requirements
- R1: After hardware reset both counters read 0, the limit reads 96, and `warn_o`, `busoff_o`, `force_reset_o` and both interrupt outputs are 0.
- R2: A CPU write (`wr_sel_i` 0 = limit, 1 = receive counter, 2 = transmit counter) takes effect on the next clock edge only while the block is held in reset mode. In operating mode a write changes nothing.
- R3: While operating, `warn_o` becomes 1 one cycle after either counter reaches or exceeds the limit, and becomes 0 one cycle after both counters are below the limit. `warn_irq_o` pulses for one cycle together with every change of `warn_o`.
- R4: While in reset mode, `warn_o` is frozen and `warn_irq_o` stays 0. A status change caused by a write is evaluated in the second cycle after reset mode is left.
- R5: An increment by the 4-bit amount saturates the receive counter at 255. A decrement at 0 leaves either counter at 0. In ACTIVE a decrement lowers a counter by one.
- R6: In ACTIVE, a transmit increment that would exceed 255 causes bus-off on the next edge. `busoff_o` becomes 1 with a one-cycle `busoff_irq_o` pulse, `tx_cnt_o` becomes 127, `rx_cnt_o` becomes 0 and `force_reset_o` becomes 1.
- R7: `force_reset_o` stays 1 until `rst_mode_i` is seen high, and it falls on the following edge. While bus-off, writes to the receive counter have no effect.
- R8: After reset mode is left in bus-off, each bus-free pulse lowers the transmit counter by one. The pulse that arrives with it at 0 (the 128th in all) clears `busoff_o` with a `busoff_irq_o` pulse, and counting events then act again.
- R9: If reset mode is entered during recovery, `busoff_o` stays 1 and the transmit counter ignores bus-free pulses until reset mode is left, after which recovery continues from the frozen value.
- R10: During bus-off in reset mode, a transmit write of 0 to 254 loads that value and clears `busoff_o` with a `busoff_irq_o` pulse, while a write of 255 is ignored. After reset mode is left, counting events are ignored until one bus-free pulse is seen.
- R11: A transmit write of 255 made in reset mode outside bus-off takes effect on exit as an overflow bus-off would: `busoff_o` becomes 1, the counters become 127 and 0, and `force_reset_o` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| rst_mode_i | input | 1 | Reset-mode control from software |
| rx_inc_i | input | 1 | Receive-error increment event |
| rx_inc_amt_i | input | 4 | Amount added by a receive increment |
| rx_dec_i | input | 1 | Receive-error decrement event |
| tx_inc_i | input | 1 | Transmit-error increment event |
| tx_inc_amt_i | input | 4 | Amount added by a transmit increment |
| tx_dec_i | input | 1 | Transmit-error decrement event |
| bus_free_i | input | 1 | One-cycle pulse per eleven recessive bits seen |
| wr_en_i | input | 1 | CPU write strobe |
| wr_sel_i | input | 2 | Write target: 0 limit, 1 receive count, 2 transmit count |
| wr_data_i | input | 8 | Write data |
| rx_cnt_o | output | 8 | Receive error count |
| tx_cnt_o | output | 8 | Transmit error count |
| ewl_o | output | 8 | Warning limit |
| warn_o | output | 1 | Either count at or above the limit |
| warn_irq_o | output | 1 | One-cycle pulse on each change of warn_o |
| busoff_o | output | 1 | Bus-off flag |
| busoff_irq_o | output | 1 | One-cycle pulse on each change of busoff_o |
| force_reset_o | output | 1 | Request to enter reset mode |

## Verification
A wrong state shows at the ports within one or two edges. A bad transition changes `busoff_o` or `force_reset_o` at once. A counter that is frozen or running when it should not shows at `tx_cnt_o` on the edge after a single event or bus-free pulse. A warning update that comes at the wrong time shows as a `warn_o` or `warn_irq_o` change one edge early or late. The bench therefore sends one event at a time and reads back the counts and flags after every edge. It walks the full 128-pulse recovery, including a freeze part way through, so a counter that is off by one shows when the recovery ends.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
    typedef enum logic [2:0] {
        FC_ACTIVE    = 3'd0,
        FC_HOLD      = 3'd1,
        FC_BOFF_HOLD = 3'd2,
        FC_RECOVER   = 3'd3,
        FC_PEND1     = 3'd4,
        FC_WAIT1     = 3'd5
    } fc_state_e;

    localparam logic [1:0] SEL_LIMIT = 2'd0;
    localparam logic [1:0] SEL_RXC   = 2'd1;
    localparam logic [1:0] SEL_TXC   = 2'd2;
endpackage

// File: rtl/fc_sat_cnt.sv
module fc_sat_cnt #(
    parameter int CNT_W = 8,
    parameter int AMT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    input  logic [AMT_W-1:0] amt,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W:0] MAX_EXT = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] sum;

    always_comb begin
        sum = {1'b0, cnt} + {{(CNT_W + 1 - AMT_W){1'b0}}, amt};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (inc) begin
            cnt <= (sum > MAX_EXT) ? MAX_EXT[CNT_W-1:0] : sum[CNT_W-1:0];
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/fc_warn.sv
module fc_warn #(
    parameter int           CNT_W   = 8,
    parameter logic [CNT_W-1:0] EWL_RST = 8'd96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lim,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             live,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] tx_cnt,
    output logic [CNT_W-1:0] ewl,
    output logic             warn,
    output logic             irq
);
    logic lvl;

    always_comb begin
        lvl = (rx_cnt >= ewl) || (tx_cnt >= ewl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ewl  <= EWL_RST;
            warn <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (wr_lim) begin
                ewl <= wr_data;
            end
            if (live) begin
                irq  <= (lvl != warn);
                warn <= lvl;
            end else begin
                irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fc_fsm.sv
module fc_fsm
    import can_fc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_mode_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             bus_free_i,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic             tx_ovf,
    output logic             busoff_o,
    output logic             busoff_irq_o,
    output logic             force_o,
    output logic             live_o,
    output logic             run_o,
    output logic             bf_dec_o,
    output logic             tx_load_o,
    output logic [CNT_W-1:0] tx_val_o,
    output logic             rx_load_o,
    output logic [CNT_W-1:0] rx_val_o,
    output logic             wr_lim_o
);
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] BOFF_LOAD = {1'b0, {(CNT_W-1){1'b1}}};

    fc_state_e state, state_n;
    logic mode_rst, hold, wr_ok, wr_tx, wr_rx, tx_full, enter_boff;

    function automatic logic is_boff(fc_state_e s);
        return (s == FC_BOFF_HOLD) || (s == FC_RECOVER);
    endfunction

    always_comb begin
        mode_rst = rst_mode_i | force_o;
        hold     = (state == FC_HOLD) || (state == FC_BOFF_HOLD) || (state == FC_PEND1);
        wr_ok    = wr_en_i & hold & mode_rst;
        wr_tx    = wr_ok & (wr_sel_i == SEL_TXC);
        wr_rx    = wr_ok & (wr_sel_i == SEL_RXC);
        tx_full  = (tx_cnt == CNT_MAX);
    end

    // next-state logic
    always_comb begin
        state_n    = state;
        enter_boff = 1'b0;
        unique case (state)
            FC_ACTIVE: begin
                if (tx_ovf) begin
                    state_n    = FC_BOFF_HOLD;
                    enter_boff = 1'b1;
                end else if (mode_rst) begin
                    state_n = FC_HOLD;
                end
            end
            FC_HOLD: begin
                if (!mode_rst) begin
                    if (tx_full) begin
                        state_n    = FC_BOFF_HOLD;
                        enter_boff = 1'b1;
                    end else begin
                        state_n = FC_ACTIVE;
                    end
                end
            end
            FC_BOFF_HOLD: begin
                if (wr_tx && wr_data_i != CNT_MAX) begin
                    state_n = FC_PEND1;
                end else if (!mode_rst) begin
                    state_n = FC_RECOVER;
                end
            end
            FC_RECOVER: begin
                if (mode_rst) begin
                    state_n = FC_BOFF_HOLD;
                end else if (bus_free_i && tx_cnt == '0) begin
                    state_n = FC_ACTIVE;
                end
            end
            FC_PEND1: begin
                if (!mode_rst) begin
                    if (tx_full) begin
                        state_n    = FC_BOFF_HOLD;
                        enter_boff = 1'b1;
                    end else begin
                        state_n = FC_WAIT1;
                    end
                end
            end
            FC_WAIT1: begin
                if (mode_rst) begin
                    state_n = FC_PEND1;
                end else if (bus_free_i) begin
                    state_n = FC_ACTIVE;
                end
            end
            default: state_n = FC_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state        <= FC_ACTIVE;
            force_o      <= 1'b0;
            busoff_irq_o <= 1'b0;
        end else begin
            state        <= state_n;
            busoff_irq_o <= is_boff(state_n) != is_boff(state);
            if (enter_boff) begin
                force_o <= 1'b1;
            end else if (rst_mode_i) begin
                force_o <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        busoff_o  = is_boff(state);
        live_o    = (state == FC_ACTIVE) || (state == FC_RECOVER) || (state == FC_WAIT1);
        run_o     = (state == FC_ACTIVE);
        bf_dec_o  = (state == FC_RECOVER) && !mode_rst && bus_free_i && (tx_cnt != '0);
        tx_load_o = enter_boff | (wr_tx & ((state != FC_BOFF_HOLD) | (wr_data_i != CNT_MAX)));
        tx_val_o  = enter_boff ? BOFF_LOAD : wr_data_i;
        rx_load_o = enter_boff | (wr_rx & (state != FC_BOFF_HOLD));
        rx_val_o  = enter_boff ? '0 : wr_data_i;
        wr_lim_o  = wr_ok & (wr_sel_i == SEL_LIMIT);
    end
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine #(
    parameter int               CNT_W   = 8,
    parameter int               AMT_W   = 4,
    parameter logic [CNT_W-1:0] EWL_RST = 8'd96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_mode_i,
    input  logic             rx_inc_i,
    input  logic [AMT_W-1:0] rx_inc_amt_i,
    input  logic             rx_dec_i,
    input  logic             tx_inc_i,
    input  logic [AMT_W-1:0] tx_inc_amt_i,
    input  logic             tx_dec_i,
    input  logic             bus_free_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] rx_cnt_o,
    output logic [CNT_W-1:0] tx_cnt_o,
    output logic [CNT_W-1:0] ewl_o,
    output logic             warn_o,
    output logic             warn_irq_o,
    output logic             busoff_o,
    output logic             busoff_irq_o,
    output logic             force_reset_o
);
    localparam logic [CNT_W:0] MAX_EXT = {1'b0, {CNT_W{1'b1}}};

    logic             run, live, bf_dec, tx_load, rx_load, wr_lim, tx_ovf;
    logic [CNT_W-1:0] tx_val, rx_val;
    logic [CNT_W:0]   tx_sum;

    always_comb begin
        tx_sum = {1'b0, tx_cnt_o} + {{(CNT_W + 1 - AMT_W){1'b0}}, tx_inc_amt_i};
        tx_ovf = run && tx_inc_i && (tx_sum > MAX_EXT);
    end

    fc_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_mode_i   (rst_mode_i),
        .wr_en_i      (wr_en_i),
        .wr_sel_i     (wr_sel_i),
        .wr_data_i    (wr_data_i),
        .bus_free_i   (bus_free_i),
        .tx_cnt       (tx_cnt_o),
        .tx_ovf       (tx_ovf),
        .busoff_o     (busoff_o),
        .busoff_irq_o (busoff_irq_o),
        .force_o      (force_reset_o),
        .live_o       (live),
        .run_o        (run),
        .bf_dec_o     (bf_dec),
        .tx_load_o    (tx_load),
        .tx_val_o     (tx_val),
        .rx_load_o    (rx_load),
        .rx_val_o     (rx_val),
        .wr_lim_o     (wr_lim)
    );

    fc_sat_cnt #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_rx_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rx_load),
        .load_val (rx_val),
        .inc      (rx_inc_i & run),
        .amt      (rx_inc_amt_i),
        .dec      (rx_dec_i & run),
        .cnt      (rx_cnt_o)
    );

    fc_sat_cnt #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_tx_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .load_val (tx_val),
        .inc      (tx_inc_i & run),
        .amt      (tx_inc_amt_i),
        .dec      ((tx_dec_i & run) | bf_dec),
        .cnt      (tx_cnt_o)
    );

    fc_warn #(.CNT_W(CNT_W), .EWL_RST(EWL_RST)) u_warn (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lim  (wr_lim),
        .wr_data (wr_data_i),
        .live    (live),
        .rx_cnt  (rx_cnt_o),
        .tx_cnt  (tx_cnt_o),
        .ewl     (ewl_o),
        .warn    (warn_o),
        .irq     (warn_irq_o)
    );
endmodule

// File: rtl/fc_checker.sv
module fc_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_mode_i,
    input logic             wr_en_i,
    input logic [CNT_W-1:0] rx_cnt_o,
    input logic [CNT_W-1:0] tx_cnt_o,
    input logic [CNT_W-1:0] ewl_o,
    input logic             warn_o,
    input logic             warn_irq_o,
    input logic             busoff_o,
    input logic             busoff_irq_o,
    input logic             force_reset_o
);
    localparam logic [CNT_W-1:0] BOFF_LOAD = {1'b0, {(CNT_W-1){1'b1}}};

    // R2
    limit_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ewl_o) |-> $past(wr_en_i && (rst_mode_i || force_reset_o)));

    // R3
    warn_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq_o == (warn_o != $past(warn_o)));

    // R4
    warn_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_mode_i) |-> ($stable(warn_o) && !warn_irq_o));

    // R6
    busoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busoff_o) |-> (tx_cnt_o == BOFF_LOAD && rx_cnt_o == '0 && force_reset_o));

    // R6
    busoff_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_irq_o == (busoff_o != $past(busoff_o)));

    // R7
    force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(force_reset_o) && !$past(rst_mode_i)) |-> force_reset_o);

    // R8
    recover_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busoff_o && $past(busoff_o)) |->
            (tx_cnt_o == $past(tx_cnt_o) || tx_cnt_o == $past(tx_cnt_o) - 1'b1));
endmodule

bind can_fault_confine fc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rst_mode_i    (rst_mode_i),
    .wr_en_i       (wr_en_i),
    .rx_cnt_o      (rx_cnt_o),
    .tx_cnt_o      (tx_cnt_o),
    .ewl_o         (ewl_o),
    .warn_o        (warn_o),
    .warn_irq_o    (warn_irq_o),
    .busoff_o      (busoff_o),
    .busoff_irq_o  (busoff_irq_o),
    .force_reset_o (force_reset_o)
);

// File: tb/can_fault_confine_tb.sv
`timescale 1ns/1ps
module can_fault_confine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_mode = 1'b0;
    logic       rx_inc = 1'b0, rx_dec = 1'b0, tx_inc = 1'b0, tx_dec = 1'b0;
    logic [3:0] rx_amt = '0, tx_amt = '0;
    logic       bus_free = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rx_cnt, tx_cnt, ewl;
    logic       warn, warn_irq, busoff, busoff_irq, force_rst;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    can_fault_confine u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rst_mode_i    (rst_mode),
        .rx_inc_i      (rx_inc),
        .rx_inc_amt_i  (rx_amt),
        .rx_dec_i      (rx_dec),
        .tx_inc_i      (tx_inc),
        .tx_inc_amt_i  (tx_amt),
        .tx_dec_i      (tx_dec),
        .bus_free_i    (bus_free),
        .wr_en_i       (wr_en),
        .wr_sel_i      (wr_sel),
        .wr_data_i     (wr_data),
        .rx_cnt_o      (rx_cnt),
        .tx_cnt_o      (tx_cnt),
        .ewl_o         (ewl),
        .warn_o        (warn),
        .warn_irq_o    (warn_irq),
        .busoff_o      (busoff),
        .busoff_irq_o  (busoff_irq),
        .force_reset_o (force_rst)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic enter_rst();
        rst_mode = 1'b1; tick(); tick();
    endtask

    task automatic exit_rst();
        rst_mode = 1'b0; tick();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; tick(); wr_en = 1'b0;
    endtask

    task automatic txi(input logic [3:0] a);
        tx_inc = 1'b1; tx_amt = a; tick(); tx_inc = 1'b0;
    endtask

    task automatic rxi(input logic [3:0] a);
        rx_inc = 1'b1; rx_amt = a; tick(); rx_inc = 1'b0;
    endtask

    task automatic pulse_bf();
        bus_free = 1'b1; tick(); bus_free = 1'b0; tick();
    endtask

    task automatic t_reset();
        chk("R1 rx", rx_cnt, 0);
        chk("R1 tx", tx_cnt, 0);
        chk("R1 limit", ewl, 96);
        chk("R1 warn", warn, 0);
        chk("R1 busoff", busoff, 0);
        chk("R1 force", force_rst, 0);
        chk("R1 irqs", {warn_irq, busoff_irq}, 0);
    endtask

    task automatic t_write_mode();
        wr(2'd0, 8'd50); wr(2'd1, 8'd10); wr(2'd2, 8'd20);
        chk("R2 op limit", ewl, 96);
        chk("R2 op rx", rx_cnt, 0);
        chk("R2 op tx", tx_cnt, 0);
        enter_rst();
        wr(2'd0, 8'd100); wr(2'd1, 8'd5); wr(2'd2, 8'd7);
        chk("R2 rst limit", ewl, 100);
        chk("R2 rst rx", rx_cnt, 5);
        chk("R2 rst tx", tx_cnt, 7);
        exit_rst();
    endtask

    task automatic t_warn();
        enter_rst();
        wr(2'd0, 8'd20); wr(2'd1, 8'd0); wr(2'd2, 8'd0);
        exit_rst(); tick();
        chk("R3 warn idle", warn, 0);
        txi(4'd8); txi(4'd8); txi(4'd4);
        chk("R3 tx 20", tx_cnt, 20);
        chk("R3 warn lag", warn, 0);
        tick();
        chk("R3 warn set", warn, 1);
        chk("R3 irq set", warn_irq, 1);
        tick();
        chk("R3 irq one cycle", warn_irq, 0);
        tx_dec = 1'b1; tick(); tx_dec = 1'b0;
        chk("R3 tx 19", tx_cnt, 19);
        tick();
        chk("R3 warn clr", warn, 0);
        chk("R3 irq clr", warn_irq, 1);
        enter_rst();
        wr(2'd1, 8'd30);
        chk("R4 rx written", rx_cnt, 30);
        chk("R4 warn held", warn, 0);
        chk("R4 irq held", warn_irq, 0);
        tick(); tick();
        chk("R4 warn still held", warn, 0);
        exit_rst();
        chk("R4 exit cycle", warn, 0);
        tick();
        chk("R4 warn after exit", warn, 1);
        chk("R4 irq after exit", warn_irq, 1);
        tick();
    endtask

    task automatic t_sat();
        enter_rst();
        wr(2'd1, 8'd250); wr(2'd2, 8'd0);
        exit_rst();
        rxi(4'd8);
        chk("R5 rx sat", rx_cnt, 255);
        rxi(4'd1);
        chk("R5 rx stays", rx_cnt, 255);
        tx_dec = 1'b1; tick(); tx_dec = 1'b0;
        chk("R5 tx floor", tx_cnt, 0);
        rx_dec = 1'b1; tick(); rx_dec = 1'b0;
        chk("R5 rx dec", rx_cnt, 254);
    endtask

    task automatic t_busoff_recover();
        enter_rst();
        wr(2'd0, 8'd96); wr(2'd1, 8'd40); wr(2'd2, 8'd250);
        exit_rst();
        txi(4'd8);
        chk("R6 busoff", busoff, 1);
        chk("R6 irq", busoff_irq, 1);
        chk("R6 tx load", tx_cnt, 127);
        chk("R6 rx clear", rx_cnt, 0);
        chk("R6 force", force_rst, 1);
        tick();
        chk("R7 force held", force_rst, 1);
        chk("R6 irq one cycle", busoff_irq, 0);
        wr(2'd1, 8'd9);
        chk("R7 rx write ignored", rx_cnt, 0);
        rst_mode = 1'b1; tick();
        chk("R7 force drop", force_rst, 0);
        tick();
        exit_rst();
        chk("R8 still busoff", busoff, 1);
        pulse_bf();
        chk("R8 first step", tx_cnt, 126);
        for (int i = 0; i < 100; i++) pulse_bf();
        chk("R8 after 101", tx_cnt, 26);
        rst_mode = 1'b1; tick();
        pulse_bf(); pulse_bf();
        chk("R9 frozen tx", tx_cnt, 26);
        chk("R9 busoff kept", busoff, 1);
        exit_rst();
        for (int i = 0; i < 26; i++) pulse_bf();
        chk("R8 at zero", tx_cnt, 0);
        chk("R8 busoff before last", busoff, 1);
        bus_free = 1'b1; tick(); bus_free = 1'b0;
        chk("R8 recovered", busoff, 0);
        chk("R8 recovered irq", busoff_irq, 1);
        tick();
        txi(4'd1);
        chk("R8 counting again", tx_cnt, 1);
    endtask

    task automatic t_clear_write();
        enter_rst();
        wr(2'd2, 8'd250);
        exit_rst();
        txi(4'd8);
        chk("R10 setup busoff", busoff, 1);
        rst_mode = 1'b1; tick(); tick();
        wr(2'd2, 8'd255);
        chk("R10 255 ignored tx", tx_cnt, 127);
        chk("R10 255 ignored flag", busoff, 1);
        wr(2'd2, 8'd5);
        chk("R10 flag cleared", busoff, 0);
        chk("R10 clear irq", busoff_irq, 1);
        chk("R10 tx loaded", tx_cnt, 5);
        exit_rst();
        txi(4'd3);
        chk("R10 events ignored", tx_cnt, 5);
        pulse_bf();
        txi(4'd3);
        chk("R10 events after bus-free", tx_cnt, 8);
    endtask

    task automatic t_force255();
        enter_rst();
        wr(2'd1, 8'd33); wr(2'd2, 8'd255);
        chk("R11 held in reset", busoff, 0);
        chk("R11 tx 255", tx_cnt, 255);
        exit_rst();
        chk("R11 busoff", busoff, 1);
        chk("R11 irq", busoff_irq, 1);
        chk("R11 tx 127", tx_cnt, 127);
        chk("R11 rx 0", rx_cnt, 0);
        chk("R11 force", force_rst, 1);
        rst_mode = 1'b1; tick(); tick();
        exit_rst();
        pulse_bf();
        chk("R11 recovery step", tx_cnt, 126);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_write_mode();
        t_warn();
        t_sat();
        t_busoff_recover();
        t_clear_write();
        t_force255();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule